// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block keeps, for recently taken branches, the first four instruction words found at the branch target address. When the fetch unit reports a taken branch, the target address is looked up in a two-way set-associative directory. On a hit the cached words come out one per cycle, starting one cycle after the lookup, so the taken branch costs a single cycle. On a miss the block claims a way in the indexed set at once and expects four consecutive words of the memory response on its refill input. The way only becomes usable after the fourth word has been stored.

The default geometry holds 128 instruction words: 16 sets of 2 ways, 4 words per way. The set index is taken from the target address bits just above the byte offset, and the rest of the address above the index forms the tag. Each set has one replacement bit that names the way to evict next. An invalidate-all input empties the directory in one cycle.

Top module: `bt_icache`

## Requirements
- R1: While reset is held and after it is released, `hit_o`, `miss_o` and `instr_vld_o` are 0, and the first lookup of any address reports a miss.
- R2: Every lookup gets exactly one of `hit_o` or `miss_o` as a one-cycle pulse in the cycle after `br_taken_i`. The byte-offset bits `br_target_i[1:0]` take no part in the lookup.
- R3: After a miss, four refill beats write the words for target, target+4, target+8 and target+12 in beat order. The way reads as valid only after the fourth beat. A lookup after fewer beats misses and restarts the refill from beat zero.
- R4: On a hit, `instr_vld_o` is 1 for exactly four cycles. The first of these is the cycle in which `hit_o` is 1, and `instr_o` carries the four cached words in address order.
- R5: Two targets that share a set index but differ in tag are held at the same time in the two ways, and both hit.
- R6: A miss claims a victim way and makes its old contents unreachable at once. The victim is an invalid way if there is one (way 0 first); otherwise it is the way that was least recently hit or filled.
- R7: A one-cycle pulse on `inval_all_i` makes every later lookup miss until new refills complete. It also cancels an ongoing refill and stream.
- R8: A lookup in the same cycle as an accepted refill beat to the same set reports a miss, starts no new refill, and leaves the ongoing refill intact.
- R9: A new lookup during a hit stream ends that stream. The output then follows the new lookup from the next cycle.
- R10: Refill beats that arrive while no refill is outstanding are ignored and change no stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval_all_i | input | 1 | Clear every valid bit and cancel refill and stream |
| br_taken_i | input | 1 | Taken-branch lookup request |
| br_target_i | input | ADDR_W | Branch target byte address |
| fill_vld_i | input | 1 | Refill beat present |
| fill_word_i | input | DATA_W | Refill instruction word |
| hit_o | output | 1 | Lookup hit, one cycle after the request |
| miss_o | output | 1 | Lookup miss, one cycle after the request |
| instr_vld_o | output | 1 | Cached target word present on `instr_o` |
| instr_o | output | DATA_W | Cached target word |

## Verification
The hardest situation to reach is a refill beat and a lookup to the same set landing in the same cycle. It occurs only when the timing of a memory response coincides with the next taken branch. The bench forces it by raising the lookup and the first beat of an outstanding refill on the same clock edge. It then finishes the remaining beats and confirms that the entry arrives intact. A partial refill that is cut short by a repeated miss and then restarted is driven the same way, by stopping the beat stream after three words.

// File: rtl/bt_icache_pkg.sv
package bt_icache_pkg;
   localparam int unsigned NUM_WAYS = 2;
   typedef logic way_t;
endpackage

// File: rtl/bt_icache_tags.sv
module bt_icache_tags
   import bt_icache_pkg::*;
#(
   parameter int unsigned SETS  = 16,
   parameter int unsigned TAG_W = 26,
   parameter int unsigned IDX_W = $clog2(SETS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush_i,
   input  logic [IDX_W-1:0]    lk_idx_i,
   input  logic [TAG_W-1:0]    lk_tag_i,
   output logic [NUM_WAYS-1:0] match_o,
   output way_t                victim_o,
   input  logic                claim_en_i,
   input  logic [IDX_W-1:0]    claim_idx_i,
   input  way_t                claim_way_i,
   input  logic [TAG_W-1:0]    claim_tag_i,
   input  logic                fill_en_i,
   input  logic [IDX_W-1:0]    fill_idx_i,
   input  way_t                fill_way_i,
   input  logic                touch_en_i,
   input  logic [IDX_W-1:0]    touch_idx_i,
   input  way_t                touch_way_i
);
   localparam int unsigned SLOTS = SETS * NUM_WAYS;

   logic [SLOTS-1:0]            vld_all;
   logic [SLOTS-1:0][TAG_W-1:0] tag_all;
   logic [SETS-1:0]             lru_all;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic [NUM_WAYS-1:0] vld_q;
      logic                lru_q;
      logic [TAG_W-1:0]    tag_q [NUM_WAYS];
      logic                claim_here, fill_here, touch_here;

      assign claim_here = claim_en_i && (claim_idx_i == IDX_W'(s));
      assign fill_here  = fill_en_i  && (fill_idx_i  == IDX_W'(s));
      assign touch_here = touch_en_i && (touch_idx_i == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= '0;
            lru_q <= 1'b0;
         end else if (flush_i) begin
            vld_q <= '0;
         end else begin
            if (claim_here) vld_q[claim_way_i] <= 1'b0;
            if (fill_here)  vld_q[fill_way_i]  <= 1'b1;
            if (fill_here)       lru_q <= ~fill_way_i;
            else if (touch_here) lru_q <= ~touch_way_i;
         end
      end

      always_ff @(posedge clk) begin
         if (claim_here) tag_q[claim_way_i] <= claim_tag_i;
      end

      for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
         assign vld_all[s*NUM_WAYS+w] = vld_q[w];
         assign tag_all[s*NUM_WAYS+w] = tag_q[w];
      end
      assign lru_all[s] = lru_q;
   end

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
      assign match_o[w] = vld_all[{lk_idx_i, 1'(w)}] &&
                          (tag_all[{lk_idx_i, 1'(w)}] == lk_tag_i);
   end

   always_comb begin
      if (!vld_all[{lk_idx_i, 1'b0}])      victim_o = 1'b0;
      else if (!vld_all[{lk_idx_i, 1'b1}]) victim_o = 1'b1;
      else                                 victim_o = lru_all[lk_idx_i];
   end

   // R7: nothing stays valid after an invalidate-all pulse
   assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (vld_all == '0))
      else $error("valid bits survive invalidate-all");

   // R3: the fourth beat leaves the filled way valid
   assert_fill_marks_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en_i |=> vld_all[{$past(fill_idx_i), $past(fill_way_i)}])
      else $error("completed refill not valid");
endmodule

// File: rtl/bt_icache_data.sv
module bt_icache_data
   import bt_icache_pkg::*;
#(
   parameter int unsigned SETS   = 16,
   parameter int unsigned RUN    = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = $clog2(SETS),
   parameter int unsigned BEAT_W = $clog2(RUN)
) (
   input  logic              clk,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  way_t              wr_way_i,
   input  logic [BEAT_W-1:0] wr_beat_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   input  way_t              rd_way_i,
   input  logic [BEAT_W-1:0] rd_beat_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int unsigned DEPTH = SETS * NUM_WAYS * RUN;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i) mem_q[{wr_idx_i, wr_way_i, wr_beat_i}] <= wr_data_i;
   end

   assign rd_data_o = mem_q[{rd_idx_i, rd_way_i, rd_beat_i}];
endmodule

// File: rtl/bt_icache_refill.sv
module bt_icache_refill
   import bt_icache_pkg::*;
#(
   parameter int unsigned RUN    = 4,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned BEAT_W = $clog2(RUN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  start_idx_i,
   input  way_t              start_way_i,
   input  logic              beat_vld_i,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output way_t              wr_way_o,
   output logic [BEAT_W-1:0] wr_beat_o,
   output logic              done_o
);
   localparam logic [BEAT_W-1:0] LAST = BEAT_W'(RUN - 1);

   logic              pend_q;
   logic [IDX_W-1:0]  idx_q;
   way_t              way_q;
   logic [BEAT_W-1:0] cnt_q;

   assign wr_en_o   = beat_vld_i && pend_q && !flush_i;
   assign wr_idx_o  = idx_q;
   assign wr_way_o  = way_q;
   assign wr_beat_o = cnt_q;
   assign done_o    = wr_en_o && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         idx_q  <= '0;
         way_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (flush_i) begin
         pend_q <= 1'b0;
      end else if (start_i) begin
         pend_q <= 1'b1;
         idx_q  <= start_idx_i;
         way_q  <= start_way_i;
         cnt_q  <= '0;
      end else if (wr_en_o) begin
         if (cnt_q == LAST) pend_q <= 1'b0;
         else               cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/bt_icache.sv
module bt_icache
   import bt_icache_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SETS   = 16,
   parameter int unsigned RUN    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inval_all_i,
   input  logic              br_taken_i,
   input  logic [ADDR_W-1:0] br_target_i,
   input  logic              fill_vld_i,
   input  logic [DATA_W-1:0] fill_word_i,
   output logic              hit_o,
   output logic              miss_o,
   output logic              instr_vld_o,
   output logic [DATA_W-1:0] instr_o
);
   localparam int unsigned IDX_W  = $clog2(SETS);
   localparam int unsigned BEAT_W = $clog2(RUN);
   localparam int unsigned OFF_W  = $clog2(DATA_W / 8);
   localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam logic [BEAT_W-1:0] LAST = BEAT_W'(RUN - 1);

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_chk_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (RUN < 2 || (RUN & (RUN - 1)) != 0) begin : g_chk_run
      $error("RUN must be a power of two of at least 2");
   end
   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_chk_data
      $error("DATA_W must be a byte multiple of at least 16");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("ADDR_W too narrow for index and offset");
   end

   logic [IDX_W-1:0]    lk_idx;
   logic [TAG_W-1:0]    lk_tag;
   logic [NUM_WAYS-1:0] match;
   way_t                victim, hit_way;
   logic                any_match, collide, hit_now, miss_now, start;
   logic                wr_en, done;
   logic [IDX_W-1:0]    wr_idx;
   way_t                wr_way;
   logic [BEAT_W-1:0]   wr_beat;
   logic                unused_off;

   assign lk_idx     = br_target_i[OFF_W +: IDX_W];
   assign lk_tag     = br_target_i[ADDR_W-1 -: TAG_W];
   assign unused_off = ^br_target_i[OFF_W-1:0];
   assign any_match  = |match;
   assign hit_way    = match[1];

   // refill has priority over a lookup in the set it is writing
   assign collide  = br_taken_i && wr_en && (wr_idx == lk_idx);
   assign hit_now  = br_taken_i && !inval_all_i && !collide && any_match;
   assign miss_now = br_taken_i && !hit_now;
   assign start    = miss_now && !inval_all_i && !collide;

   bt_icache_tags #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (inval_all_i),
      .lk_idx_i    (lk_idx),
      .lk_tag_i    (lk_tag),
      .match_o     (match),
      .victim_o    (victim),
      .claim_en_i  (start),
      .claim_idx_i (lk_idx),
      .claim_way_i (victim),
      .claim_tag_i (lk_tag),
      .fill_en_i   (done),
      .fill_idx_i  (wr_idx),
      .fill_way_i  (wr_way),
      .touch_en_i  (hit_now),
      .touch_idx_i (lk_idx),
      .touch_way_i (hit_way)
   );

   bt_icache_refill #(.RUN(RUN), .IDX_W(IDX_W), .BEAT_W(BEAT_W)) u_refill (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (inval_all_i),
      .start_i     (start),
      .start_idx_i (lk_idx),
      .start_way_i (victim),
      .beat_vld_i  (fill_vld_i),
      .wr_en_o     (wr_en),
      .wr_idx_o    (wr_idx),
      .wr_way_o    (wr_way),
      .wr_beat_o   (wr_beat),
      .done_o      (done)
   );

   logic              hit_q, miss_q, str_act_q;
   logic [IDX_W-1:0]  str_idx_q;
   way_t              str_way_q;
   logic [BEAT_W-1:0] str_beat_q;

   bt_icache_data #(.SETS(SETS), .RUN(RUN), .DATA_W(DATA_W),
                    .IDX_W(IDX_W), .BEAT_W(BEAT_W)) u_data (
      .clk       (clk),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_way_i  (wr_way),
      .wr_beat_i (wr_beat),
      .wr_data_i (fill_word_i),
      .rd_idx_i  (str_idx_q),
      .rd_way_i  (str_way_q),
      .rd_beat_i (str_beat_q),
      .rd_data_o (instr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q      <= 1'b0;
         miss_q     <= 1'b0;
         str_act_q  <= 1'b0;
         str_idx_q  <= '0;
         str_way_q  <= 1'b0;
         str_beat_q <= '0;
      end else begin
         hit_q  <= hit_now;
         miss_q <= miss_now;
         if (inval_all_i) begin
            str_act_q <= 1'b0;
         end else if (br_taken_i) begin
            str_act_q  <= hit_now;
            str_idx_q  <= lk_idx;
            str_way_q  <= hit_way;
            str_beat_q <= '0;
         end else if (str_act_q) begin
            if (str_beat_q == LAST) str_act_q  <= 1'b0;
            else                    str_beat_q <= str_beat_q + 1'b1;
         end
      end
   end

   assign hit_o       = hit_q;
   assign miss_o      = miss_q;
   assign instr_vld_o = str_act_q;

   // R2: one answer per lookup, in the following cycle
   assert_one_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken_i |=> (hit_o ^ miss_o))
      else $error("lookup answered wrongly");

   // R4: a hit delivers its first word in the same cycle
   assert_hit_streams_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> instr_vld_o)
      else $error("hit without word");

   // R8: a colliding lookup reports a miss
   assert_collide_misses_R8: assert property (@(posedge clk) disable iff (!rst_n)
      collide |=> (miss_o && !instr_vld_o))
      else $error("collision did not miss");
endmodule

// File: tb/tb_bt_icache.sv
module tb_bt_icache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inval_all_i = 1'b0;
   logic        br_taken_i = 1'b0;
   logic [31:0] br_target_i = '0;
   logic        fill_vld_i = 1'b0;
   logic [31:0] fill_word_i = '0;
   logic        hit_o, miss_o, instr_vld_o;
   logic [31:0] instr_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bt_icache dut (
      .clk(clk), .rst_n(rst_n), .inval_all_i(inval_all_i),
      .br_taken_i(br_taken_i), .br_target_i(br_target_i),
      .fill_vld_i(fill_vld_i), .fill_word_i(fill_word_i),
      .hit_o(hit_o), .miss_o(miss_o), .instr_vld_o(instr_vld_o), .instr_o(instr_o)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic        fill;
      logic        hit;
   } vec_t;

   // address = tag<<6 | set<<2 | byte offset
   localparam vec_t TABLE [13] = '{
      '{32'h0000_004C, 1'b1, 1'b0},  // tag1 set3: empty -> miss (R1 R2)
      '{32'h0000_004C, 1'b0, 1'b1},  // filled -> hit (R3 R4)
      '{32'h0000_008C, 1'b1, 1'b0},  // tag2 set3 into way1
      '{32'h0000_004C, 1'b0, 1'b1},  // both ways live (R5)
      '{32'h0000_008C, 1'b0, 1'b1},  // (R5)
      '{32'h0000_00CC, 1'b1, 1'b0},  // tag3 evicts LRU tag1 (R6)
      '{32'h0000_008C, 1'b0, 1'b1},  // tag2 kept (R6)
      '{32'h0000_004C, 1'b1, 1'b0},  // tag1 gone, evicts tag3 (R6)
      '{32'h0000_00CC, 1'b0, 1'b0},  // tag3 gone; miss claims tag2 way (R6)
      '{32'h0000_004C, 1'b0, 1'b1},  // tag1 still held
      '{32'h0000_008C, 1'b0, 1'b0},  // claimed way no longer hits (R6)
      '{32'h0000_015C, 1'b1, 1'b0},  // tag5 set7
      '{32'h0000_015E, 1'b0, 1'b1}   // byte offset ignored (R2)
   };

   function automatic logic [31:0] word_of(input logic [31:0] a, input int k);
      return (({a[31:2], 2'b00}) ^ 32'h5A00_0000) + 32'(k);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic lookup(input logic [31:0] a, input logic exp_hit, input string req);
      @(negedge clk);
      br_taken_i  = 1'b1;
      br_target_i = a;
      @(negedge clk);
      br_taken_i = 1'b0;
      chk({req, " hit_o"}, 32'(hit_o), 32'(exp_hit));
      chk({req, " miss_o"}, 32'(miss_o), 32'(!exp_hit));
      if (exp_hit) begin
         for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            chk({req, " instr_vld_o"}, 32'(instr_vld_o), 32'd1);
            chk({req, " instr_o"}, instr_o, word_of(a, k));
         end
         @(negedge clk);
      end
      chk({req, " stream idle"}, 32'(instr_vld_o), 32'd0);
   endtask

   task automatic refill(input logic [31:0] a, input int beats);
      for (int k = 0; k < beats; k++) begin
         @(negedge clk);
         fill_vld_i  = 1'b1;
         fill_word_i = word_of(a, k);
      end
      @(negedge clk);
      fill_vld_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset hit_o", 32'(hit_o), 32'd0);
      chk("R1 reset miss_o", 32'(miss_o), 32'd0);
      chk("R1 reset instr_vld_o", 32'(instr_vld_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", 32'(hit_o | miss_o | instr_vld_o), 32'd0);

      for (int i = 0; i < 13; i++) begin
         lookup(TABLE[i].addr, TABLE[i].hit, $sformatf("R2-R6 table[%0d]", i));
         if (TABLE[i].fill) refill(TABLE[i].addr, 4);
      end

      // R3: partial refill does not validate; repeated miss restarts
      lookup(32'h0000_0224, 1'b0, "R3 first miss");
      refill(32'h0000_0224, 3);
      lookup(32'h0000_0224, 1'b0, "R3 after three beats");
      refill(32'h0000_0224, 4);
      lookup(32'h0000_0224, 1'b0 | 1'b1, "R3 after full refill");

      // R10: stray beats with no refill outstanding
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         fill_vld_i  = 1'b1;
         fill_word_i = 32'hDEAD_0000 + 32'(k);
      end
      @(negedge clk);
      fill_vld_i = 1'b0;
      lookup(32'h0000_0224, 1'b1, "R10 stray beats ignored");

      // R8: lookup to the refilling set in the same cycle as a beat
      lookup(32'h0000_0128, 1'b0, "R8 open refill");
      @(negedge clk);
      fill_vld_i  = 1'b1;
      fill_word_i = word_of(32'h0000_0128, 0);
      br_taken_i  = 1'b1;
      br_target_i = 32'h0000_01A8;
      @(negedge clk);
      br_taken_i = 1'b0;
      chk("R8 collide miss_o", 32'(miss_o), 32'd1);
      chk("R8 collide hit_o", 32'(hit_o), 32'd0);
      fill_word_i = word_of(32'h0000_0128, 1);
      for (int k = 2; k < 4; k++) begin
         @(negedge clk);
         fill_word_i = word_of(32'h0000_0128, k);
      end
      @(negedge clk);
      fill_vld_i = 1'b0;
      lookup(32'h0000_0128, 1'b1, "R8 refill intact");

      // R9: a new lookup cuts the running stream short
      @(negedge clk);
      br_taken_i  = 1'b1;
      br_target_i = 32'h0000_0224;
      @(negedge clk);
      br_taken_i = 1'b0;
      chk("R9 first word", instr_o, word_of(32'h0000_0224, 0));
      @(negedge clk);
      chk("R9 second word", instr_o, word_of(32'h0000_0224, 1));
      br_taken_i  = 1'b1;
      br_target_i = 32'h0000_015C;
      @(negedge clk);
      br_taken_i = 1'b0;
      chk("R9 new hit_o", 32'(hit_o), 32'd1);
      for (int k = 0; k < 4; k++) begin
         if (k > 0) @(negedge clk);
         chk("R9 new stream valid", 32'(instr_vld_o), 32'd1);
         chk("R9 new stream word", instr_o, word_of(32'h0000_015C, k));
      end
      @(negedge clk);
      chk("R9 stream ends", 32'(instr_vld_o), 32'd0);

      // R7: invalidate-all
      @(negedge clk);
      inval_all_i = 1'b1;
      @(negedge clk);
      inval_all_i = 1'b0;
      lookup(32'h0000_015C, 1'b0, "R7 after invalidate");
      lookup(32'h0000_004C, 1'b0, "R7 after invalidate other set");
      refill(32'h0000_004C, 4);
      lookup(32'h0000_004C, 1'b1, "R7 refill after invalidate");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual run incomplete expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule